// File: doc/BRIEF.md
# Sleep-State Power Plane Sequencer

This block is the digital core of a power-plane controller that supports system sleep. It reads two active-low sleep request pins and decodes them into one of three system states: active, suspend-to-RAM or soft-off. From that state it drives logic-level on/off commands for a memory plane and for two auxiliary planes (a 3.3V auxiliary plane and a 5V auxiliary plane), plus a voltage select for the memory plane. Analog regulation, soft-start and current limiting belong to other blocks.

The sleep pins often travel a long way across a board. For that reason they pass through a two-flop synchronizer, and every change restarts a deglitch timer. A new state is taken up only when the timer expires and the pins then ask for a legal move. The only legal moves are from active into either sleep state and from either sleep state back to active. Two strap inputs decide whether each auxiliary plane stays powered during sleep. The block follows the straps while it is active, and also while it is held off because bias is low or shutdown is asserted. It freezes the straps while asleep. All command pins are plain registered control signals. There is no streaming interface, so no handshake applies.

Top module: `pwr_sleep_seq`

## Requirements
- R1: The pin pair {slp_off_n, slp_ram_n} decodes as follows: 2'b11 requests active, 2'b10 requests suspend-to-RAM and 2'b00 requests soft-off.
- R2: Suppose a pin change is followed by no further change. The plane commands then update on the (TMO_CYC+3)-th rising edge after the change, and not before.
- R3: Any change of either sleep pin during the deglitch window restarts the window. A pulse shorter than TMO_CYC cycles leaves the commands unchanged.
- R4: A request to go directly between suspend-to-RAM and soft-off, in either direction, is ignored and the current state is held.
- R5: The combination 2'b01 (slp_off_n=0, slp_ram_n=1) is not valid and leaves the state and the commands unchanged.
- R6: mem_on is 1 in active and in suspend-to-RAM, and 0 in soft-off.
- R7: mem_v33 is the mem_sel input delayed by one register. A value of 1 selects 3.3V and 0 selects 2.5V.
- R8: aux3_on and aux5_on are 1 in active. In either sleep state each one equals its latched strap.
- R9: The straps are latched on every edge while the block is active or held. They are frozen while it is in a sleep state.
- R10: While bias_ok=0 or shdn=1, all three on commands are 0 from the next edge, the state returns to active and the timer is cleared. After release, sleep pins that are still asserted start a fresh deglitch window.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slp_ram_n | input | 1 | Suspend-to-RAM request, active low, asynchronous |
| slp_off_n | input | 1 | Soft-off request, active low, asynchronous |
| en_aux3 | input | 1 | Strap: 3.3V auxiliary plane stays on in sleep |
| en_aux5 | input | 1 | Strap: 5V auxiliary plane stays on in sleep |
| mem_sel | input | 1 | Memory voltage select, 1 = 3.3V, 0 = 2.5V |
| bias_ok | input | 1 | Bias above power-on-reset level |
| shdn | input | 1 | Shutdown request, active high |
| mem_on | output | 1 | Memory plane on command |
| mem_v33 | output | 1 | Memory plane level select |
| aux3_on | output | 1 | 3.3V auxiliary plane on command |
| aux5_on | output | 1 | 5V auxiliary plane on command |

## Verification
The pins are driven through clean entries into each sleep state and back. A cycle-exact check on the commit edge separates the correct latency from an off-by-one timer. Short pulses, and a second pin change in the middle of a window, show whether the window restarts or commits early. Requests to move directly between the two sleep states and the invalid pin combination show whether illegal moves are rejected. Strap changes made during sleep and during a shutdown hold show the difference between the frozen latch and the re-latch on release.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_ACT = 2'd0,
    ST_STR = 2'd1,
    ST_OFF = 2'd2
  } pwr_st_e;

  // pin pair {off_n, ram_n}
  localparam logic [1:0] PIN_ACT = 2'b11;
  localparam logic [1:0] PIN_STR = 2'b10;
  localparam logic [1:0] PIN_OFF = 2'b00;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '1;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_seq_deglitch.sv
module pwr_seq_deglitch #(
  parameter int TMO_CYC = 40000,
  localparam int CW     = $clog2(TMO_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [1:0] pins_s,
  output logic       commit,
  output logic [1:0] req
);
  logic [1:0]    last_q;
  logic [CW-1:0] cnt_q;
  logic          chg;

  assign chg    = (pins_s != last_q);
  assign commit = !hold && !chg && (cnt_q == CW'(1));
  assign req    = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 2'b11;
      cnt_q  <= '0;
    end else if (hold) begin
      last_q <= 2'b11;
      cnt_q  <= '0;
    end else begin
      last_q <= pins_s;
      if (chg)                cnt_q <= CW'(TMO_CYC);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R3: a change reloads the window, so no commit on the following edge
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !hold) |=> !commit);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       commit,
  input  logic [1:0] req,
  input  logic       en_aux3,
  input  logic       en_aux5,
  input  logic       mem_sel,
  output logic       mem_on,
  output logic       mem_v33,
  output logic       aux3_on,
  output logic       aux5_on
);
  pwr_st_e st_q, st_d, req_st;
  logic    req_ok;
  logic    en3_q, en5_q, en3_d, en5_d;

  always_comb begin
    req_ok = 1'b1;
    req_st = ST_ACT;
    unique case (req)
      PIN_ACT: req_st = ST_ACT;
      PIN_STR: req_st = ST_STR;
      PIN_OFF: req_st = ST_OFF;
      default: req_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (hold) st_d = ST_ACT;
    else if (commit && req_ok) begin
      if (st_q == ST_ACT) st_d = req_st;
      else if (req_st == ST_ACT) st_d = ST_ACT;
    end
  end

  assign en3_d = (st_q == ST_ACT || hold) ? en_aux3 : en3_q;
  assign en5_d = (st_q == ST_ACT || hold) ? en_aux5 : en5_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ACT;
      en3_q   <= 1'b0;
      en5_q   <= 1'b0;
      mem_on  <= 1'b0;
      mem_v33 <= 1'b0;
      aux3_on <= 1'b0;
      aux5_on <= 1'b0;
    end else begin
      st_q    <= st_d;
      en3_q   <= en3_d;
      en5_q   <= en5_d;
      mem_v33 <= mem_sel;
      mem_on  <= !hold && (st_d != ST_OFF);
      aux3_on <= !hold && ((st_d == ST_ACT) || en3_d);
      aux5_on <= !hold && ((st_d == ST_ACT) || en5_d);
    end
  end

  a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!mem_on && !aux3_on && !aux5_on));
  a_r4_no_str_to_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STR) |=> (st_q != ST_OFF));
  a_r4_no_off_to_str: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |=> (st_q != ST_STR));
  a_r2_move_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !commit) |=> $stable(st_q));
  a_r9_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ACT && !hold) |=> ($stable(en3_q) && $stable(en5_q)));
  a_r6_mem_plane: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (mem_on == (st_q != ST_OFF)));
endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq #(
  parameter int TMO_CYC     = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slp_ram_n,
  input  logic slp_off_n,
  input  logic en_aux3,
  input  logic en_aux5,
  input  logic mem_sel,
  input  logic bias_ok,
  input  logic shdn,
  output logic mem_on,
  output logic mem_v33,
  output logic aux3_on,
  output logic aux5_on
);
  logic [1:0] pins_s, req;
  logic       commit, hold;

  assign hold = !bias_ok || shdn;

  pwr_seq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({slp_off_n, slp_ram_n}), .q(pins_s));

  pwr_seq_deglitch #(.TMO_CYC(TMO_CYC)) u_dgl (
    .clk(clk), .rst_n(rst_n), .hold(hold), .pins_s(pins_s),
    .commit(commit), .req(req));

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold(hold), .commit(commit), .req(req),
    .en_aux3(en_aux3), .en_aux5(en_aux5), .mem_sel(mem_sel),
    .mem_on(mem_on), .mem_v33(mem_v33), .aux3_on(aux3_on), .aux5_on(aux5_on));
endmodule

// File: tb/pwr_sleep_seq_tb.sv
module pwr_sleep_seq_tb;
  localparam int TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slp_ram_n = 1'b1, slp_off_n = 1'b1, en_aux3 = 1'b0, en_aux5 = 1'b0;
  logic mem_sel = 1'b0, bias_ok = 1'b1, shdn = 1'b0;
  logic mem_on, mem_v33, aux3_on, aux5_on;
  int   n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pwr_sleep_seq #(.TMO_CYC(TMO)) u_dut (.*);

  // behavioural reference: 0 active, 1 suspend-to-RAM, 2 soft-off
  int m_s1, m_s2, m_last, m_cnt, m_st, m_e3, m_e5;
  bit e_mem, e_v33, e_a3, e_a5;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 3; m_s2 = 3; m_last = 3; m_cnt = 0; m_st = 0; m_e3 = 0; m_e5 = 0;
      e_mem = 0; e_v33 = 0; e_a3 = 0; e_a5 = 0;
    end else begin
      bit h, cm; int rq, nst;
      h  = !bias_ok || shdn;
      cm = !h && (m_s2 == m_last) && (m_cnt == 1);
      rq = (m_last == 3) ? 0 : (m_last == 2) ? 1 : (m_last == 0) ? 2 : -1;
      nst = m_st;
      if (h) nst = 0;
      else if (cm && rq >= 0 && ((m_st == 0) || (rq == 0))) nst = rq;
      if (m_st == 0 || h) begin m_e3 = en_aux3; m_e5 = en_aux5; end
      e_v33 = mem_sel;
      e_mem = !h && nst != 2;
      e_a3  = !h && (nst == 0 || m_e3 != 0);
      e_a5  = !h && (nst == 0 || m_e5 != 0);
      m_st  = nst;
      if (h) begin m_last = 3; m_cnt = 0; end
      else begin
        if (m_s2 != m_last) m_cnt = TMO; else if (m_cnt > 0) m_cnt--;
        m_last = m_s2;
      end
      m_s2 = m_s1;
      m_s1 = {slp_off_n, slp_ram_n};
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    chk(mem_on,  e_mem, "R6 mem_on model");
    chk(mem_v33, e_v33, "R7 mem_v33 model");
    chk(aux3_on, e_a3,  "R8 aux3_on model");
    chk(aux5_on, e_a5,  "R8 aux5_on model");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        cyc(4);
        chk(mem_on | aux3_on | aux5_on | mem_v33, 1'b0, "R11 reset outputs");
        rst_n = 1'b1; en_aux3 = 1'b1; en_aux5 = 1'b0;
        cyc(3);
        chk(mem_on & aux3_on & aux5_on, 1'b1, "R1 active all on");
        mem_sel = 1'b1; cyc(1);
        chk(mem_v33, 1'b1, "R7 select 3.3V");
        slp_ram_n = 1'b0;
        cyc(TMO + 2);
        chk(aux5_on, 1'b1, "R2 no early commit");
        cyc(1);
        chk(aux5_on, 1'b0, "R2 commit edge");
        chk(mem_on & aux3_on, 1'b1, "R1 suspend-to-RAM");
        en_aux3 = 1'b0; en_aux5 = 1'b1; cyc(5);
        chk(aux3_on, 1'b1, "R9 strap frozen aux3");
        chk(aux5_on, 1'b0, "R9 strap frozen aux5");
        slp_off_n = 1'b0; cyc(TMO + 8);
        chk(mem_on, 1'b1, "R4 ram to off rejected");
        slp_ram_n = 1'b1; cyc(TMO + 8);
        chk(mem_on & !aux5_on, 1'b1, "R5 invalid pair held");
        slp_off_n = 1'b1; cyc(TMO + 8);
        chk(mem_on & aux3_on & aux5_on, 1'b1, "R1 back to active");
        slp_ram_n = 1'b0; cyc(5); slp_ram_n = 1'b1; cyc(TMO + 8);
        chk(aux3_on, 1'b1, "R3 short pulse ignored");
        slp_ram_n = 1'b0; cyc(10); slp_off_n = 1'b0;
        cyc(TMO - 6);
        chk(aux3_on, 1'b1, "R3 window restarted");
        cyc(TMO);
        chk(mem_on | aux3_on, 1'b0, "R6 soft-off mem off");
        chk(aux5_on, 1'b1, "R8 aux5 strap in sleep");
        slp_off_n = 1'b1; cyc(TMO + 8);
        chk(mem_on, 1'b0, "R4 off to ram rejected");
        shdn = 1'b1; en_aux3 = 1'b1; cyc(1);
        chk(mem_on | aux3_on | aux5_on, 1'b0, "R10 shutdown off");
        cyc(3); shdn = 1'b0; cyc(1);
        chk(mem_on & aux3_on & aux5_on, 1'b1, "R10 release to active");
        cyc(TMO + 4);
        chk(mem_on & aux3_on, 1'b1, "R10 fresh window to suspend");
        slp_ram_n = 1'b1; cyc(TMO + 6);
        bias_ok = 1'b0; cyc(2);
        chk(mem_on, 1'b0, "R10 low bias off");
        bias_ok = 1'b1; cyc(4);
      end
      begin
        cyc(100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule